// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block lets several hardware threads share one word-addressed memory and build atomic read-modify-write sequences from a pair of operations. One is a load-linked, which reads a word and reserves it. The other is a store-conditional, which writes only if that reservation is still intact. Every requester has one request lane. On that lane it may issue a plain load, a plain store, a load-linked or a store-conditional. The monitor sees all of these requests, so it can tell when any write reaches a reserved word.

Each requester holds at most one reservation. A reservation covers one 4-byte-aligned word. Any write to that word by any requester removes the reservation. A store-conditional always consumes the reservation of the requester that issued it. The store-conditional answers 1 when it wrote and 0 when it did not, and software retries on 0. A lock built from these operations is released with a plain store of zero. When several requests arrive in the same cycle, they are applied in lane order, lowest index first. Each request sees the memory contents and reservation state left by the lanes before it.

Top module: `llsc_monitor`

## Requirements
- R1: After reset the memory is all zero, no requester holds a reservation, and `rsp_valid_o` is 0.
- R2: Each request gets exactly one response on its own lane, one cycle later. A plain load (op 2'b00) or a load-linked (op 2'b10) returns the word held at the address.
- R3: A plain store (op 2'b01) writes the word selected by address bits [ADDR_W-1:2]. Address bits [1:0] are ignored, and the response data of a store is zero.
- R4: A store-conditional (op 2'b11) to the word reserved by the same requester's earlier load-linked writes its data and returns 1, provided no write has reached that word since.
- R5: A write to a word by any requester removes every reservation on that word. The write may be a plain store, including a store of zero that releases a lock, or a successful store-conditional. A later store-conditional against such a reservation returns 0 and leaves memory unchanged.
- R6: A store-conditional from a requester with no reservation, or with a reservation on a different word, returns 0 and writes nothing. Its result is always 0 or 1 in bit 0, with all other bits zero.
- R7: A store-conditional removes its own requester's reservation whether it succeeds or fails. A second store-conditional with no new load-linked therefore fails.
- R8: Requests in the same cycle take effect in lane order, lowest lane first. A later lane sees data written by an earlier lane, and a later store removes a reservation an earlier lane set in that cycle. At most one of several same-cycle store-conditionals to one word succeeds.
- R9: Neither a write to another word nor a load-linked by another requester disturbs an existing reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_REQ | Request strobe, one bit per lane |
| req_op_i | input | 2*NUM_REQ | Operation per lane: 00 load, 01 store, 10 load-linked, 11 store-conditional |
| req_addr_i | input | ADDR_W*NUM_REQ | Byte address per lane |
| req_wdata_i | input | DATA_W*NUM_REQ | Write data per lane |
| rsp_valid_o | output | NUM_REQ | Response strobe, one cycle after the request |
| rsp_data_o | output | DATA_W*NUM_REQ | Read word, store-conditional flag, or zero for a store |

## Verification
A stale reservation shows up on the next store-conditional from that lane, which returns 1 where 0 is due. A reservation lost by mistake returns 0 where 1 is due. Either error is visible one cycle after the store-conditional, and a follow-up load one cycle later shows whether the word changed. Wrong ordering within a cycle shows in the response of the higher lane in that same cycle: it returns stale data or a second winning flag. The bench therefore pairs every store-conditional with a read-back and drives both lanes together at the boundaries.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LL    = 2'b10,
    OP_SC    = 2'b11
  } op_e;
endpackage

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
  parameter int NUM_PORTS = 2,
  parameter int WORD_AW   = 6,
  parameter int DATA_W    = 32,
  localparam int DEPTH    = 1 << WORD_AW
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [NUM_PORTS-1:0]                wr_en_i,
  input  logic [NUM_PORTS-1:0][WORD_AW-1:0]   wr_word_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]    wr_data_i,
  input  logic [NUM_PORTS-1:0][WORD_AW-1:0]   rd_word_i,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]    rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // highest port wins on a same-word collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (wr_en_i[p]) mem_q[wr_word_i[p]] <= wr_data_i[p];
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    assign rd_data_o[p] = mem_q[rd_word_i[p]];
  end
endmodule

// File: rtl/llsc_serialiser.sv
module llsc_serialiser #(
  parameter int NUM_REQ = 2,
  parameter int WORD_AW = 6,
  parameter int DATA_W  = 32
) (
  input  logic [NUM_REQ-1:0]               req_valid_i,
  input  logic [NUM_REQ-1:0][1:0]          req_op_i,
  input  logic [NUM_REQ-1:0][WORD_AW-1:0]  req_word_i,
  input  logic [NUM_REQ-1:0][DATA_W-1:0]   req_wdata_i,
  input  logic [NUM_REQ-1:0][DATA_W-1:0]   mem_rd_i,
  input  logic [NUM_REQ-1:0]               resv_valid_i,
  input  logic [NUM_REQ-1:0][WORD_AW-1:0]  resv_word_i,
  output logic [NUM_REQ-1:0][DATA_W-1:0]   rd_data_o,
  output logic [NUM_REQ-1:0]               sc_ok_o,
  output logic [NUM_REQ-1:0]               wr_en_o
);
  import llsc_pkg::*;

  logic [NUM_REQ-1:0] live;

  // lanes applied in index order; lane k sees effects of lanes below it
  always_comb begin
    wr_en_o   = '0;
    sc_ok_o   = '0;
    rd_data_o = '0;
    live      = '0;
    for (int k = 0; k < NUM_REQ; k++) begin
      rd_data_o[k] = mem_rd_i[k];
      live[k]      = resv_valid_i[k];
      for (int j = 0; j < k; j++) begin
        if (wr_en_o[j] && req_word_i[j] == req_word_i[k]) rd_data_o[k] = req_wdata_i[j];
        if (wr_en_o[j] && req_word_i[j] == resv_word_i[k]) live[k] = 1'b0;
      end
      sc_ok_o[k] = req_valid_i[k] && (req_op_i[k] == OP_SC) && live[k] &&
                   (resv_word_i[k] == req_word_i[k]);
      wr_en_o[k] = req_valid_i[k] && ((req_op_i[k] == OP_STORE) || sc_ok_o[k]);
    end
  end
endmodule

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
  parameter int NUM_REQ = 2,
  parameter int WORD_AW = 6,
  parameter int IDX     = 0
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_REQ-1:0]               req_valid_i,
  input  logic [NUM_REQ-1:0][1:0]          req_op_i,
  input  logic [NUM_REQ-1:0][WORD_AW-1:0]  req_word_i,
  input  logic [NUM_REQ-1:0]               wr_en_i,
  output logic                             resv_valid_o,
  output logic [WORD_AW-1:0]               resv_word_o
);
  import llsc_pkg::*;

  logic               valid_q, valid_d;
  logic [WORD_AW-1:0] word_q, word_d;

  // replay this cycle's lanes in order against the slot
  always_comb begin
    valid_d = valid_q;
    word_d  = word_q;
    for (int j = 0; j < NUM_REQ; j++) begin
      if (req_valid_i[j] && j == IDX && req_op_i[j] == OP_LL) begin
        valid_d = 1'b1;
        word_d  = req_word_i[j];
      end else if (req_valid_i[j] && j == IDX && req_op_i[j] == OP_SC) begin
        valid_d = 1'b0;
      end else if (wr_en_i[j] && req_word_i[j] == word_d) begin
        valid_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= valid_d;
      word_q  <= word_d;
    end
  end

  assign resv_valid_o = valid_q;
  assign resv_word_o  = word_q;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NUM_REQ = 2,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int WORD_AW = ADDR_W - 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_REQ-1:0]          req_valid_i,
  input  logic [2*NUM_REQ-1:0]        req_op_i,
  input  logic [ADDR_W*NUM_REQ-1:0]   req_addr_i,
  input  logic [DATA_W*NUM_REQ-1:0]   req_wdata_i,
  output logic [NUM_REQ-1:0]          rsp_valid_o,
  output logic [DATA_W*NUM_REQ-1:0]   rsp_data_o
);
  import llsc_pkg::*;

  logic [NUM_REQ-1:0][1:0]         op;
  logic [NUM_REQ-1:0][ADDR_W-1:0]  addr;
  logic [NUM_REQ-1:0][WORD_AW-1:0] word;
  logic [NUM_REQ-1:0][DATA_W-1:0]  wdata;
  logic [NUM_REQ-1:0][DATA_W-1:0]  mem_rd, fwd_rd, rsp_d, rsp_q;
  logic [NUM_REQ-1:0]              sc_ok, wr_en, resv_valid, rsp_valid_q;
  logic [NUM_REQ-1:0][WORD_AW-1:0] resv_word;

  assign op    = req_op_i;
  assign addr  = req_addr_i;
  assign wdata = req_wdata_i;

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_lane
    assign word[k] = addr[k][ADDR_W-1:2];

    llsc_resv_slot #(
      .NUM_REQ (NUM_REQ),
      .WORD_AW (WORD_AW),
      .IDX     (k)
    ) i_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_valid_i  (req_valid_i),
      .req_op_i     (op),
      .req_word_i   (word),
      .wr_en_i      (wr_en),
      .resv_valid_o (resv_valid[k]),
      .resv_word_o  (resv_word[k])
    );

    always_comb begin
      unique case (op[k])
        OP_LOAD, OP_LL: rsp_d[k] = fwd_rd[k];
        OP_SC:          rsp_d[k] = {{(DATA_W-1){1'b0}}, sc_ok[k]};
        default:        rsp_d[k] = '0;
      endcase
    end
  end

  llsc_serialiser #(
    .NUM_REQ (NUM_REQ),
    .WORD_AW (WORD_AW),
    .DATA_W  (DATA_W)
  ) i_serialiser (
    .req_valid_i  (req_valid_i),
    .req_op_i     (op),
    .req_word_i   (word),
    .req_wdata_i  (wdata),
    .mem_rd_i     (mem_rd),
    .resv_valid_i (resv_valid),
    .resv_word_i  (resv_word),
    .rd_data_o    (fwd_rd),
    .sc_ok_o      (sc_ok),
    .wr_en_o      (wr_en)
  );

  llsc_word_mem #(
    .NUM_PORTS (NUM_REQ),
    .WORD_AW   (WORD_AW),
    .DATA_W    (DATA_W)
  ) i_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_word_i (word),
    .wr_data_i (wdata),
    .rd_word_i (word),
    .rd_data_o (mem_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= '0;
      rsp_q       <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      for (int k = 0; k < NUM_REQ; k++) begin
        if (req_valid_i[k]) rsp_q[k] <= rsp_d[k];
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_q;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NUM_REQ = 2,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_REQ-1:0]        req_valid_i,
  input logic [2*NUM_REQ-1:0]      req_op_i,
  input logic [ADDR_W*NUM_REQ-1:0] req_addr_i,
  input logic [NUM_REQ-1:0]        rsp_valid_o,
  input logic [DATA_W*NUM_REQ-1:0] rsp_data_o
);
  logic               past_ok;
  logic [NUM_REQ-1:0] is_sc, is_st, is_ll, had_ll;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_k
    assign is_sc[k] = req_valid_i[k] && req_op_i[2*k +: 2] == 2'b11;
    assign is_st[k] = req_valid_i[k] && req_op_i[2*k +: 2] == 2'b01;
    assign is_ll[k] = req_valid_i[k] && req_op_i[2*k +: 2] == 2'b10;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      had_ll[k] <= 1'b0;
      else if (is_ll[k]) had_ll[k] <= 1'b1;
      else if (is_sc[k]) had_ll[k] <= 1'b0;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !past_ok |-> !rsp_valid_o[k]);

    a_r2_one_rsp_per_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> rsp_valid_o[k] == $past(req_valid_i[k]));

    a_r3_store_rsp_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(is_st[k]) |-> rsp_data_o[DATA_W*k +: DATA_W] == '0);

    a_r6_sc_flag_single_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(is_sc[k]) |-> rsp_data_o[DATA_W*k+1 +: DATA_W-1] == '0);

    a_r4_sc_win_needs_ll: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok && $past(is_sc[k]) && rsp_data_o[DATA_W*k] |-> $past(had_ll[k]));

    for (genvar m = k + 1; m < NUM_REQ; m++) begin : g_m
      a_r8_single_sc_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
        past_ok && $past(is_sc[k] && is_sc[m] &&
          req_addr_i[ADDR_W*k+2 +: ADDR_W-2] == req_addr_i[ADDR_W*m+2 +: ADDR_W-2])
        |-> !(rsp_data_o[DATA_W*k] && rsp_data_o[DATA_W*m]));
    end
  end
endmodule

bind llsc_monitor llsc_monitor_chk #(
  .NUM_REQ (NUM_REQ),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) i_llsc_monitor_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_data_o  (rsp_data_o)
);

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
  localparam int N  = 2;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

  typedef struct {
    int          lane;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_wdata = '0;
  logic [N-1:0]    rsp_valid;
  logic [DW*N-1:0] rsp_data;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  llsc_monitor #(.NUM_REQ(N), .ADDR_W(AW), .DATA_W(DW)) i_llsc_monitor (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_op_i    (req_op),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data)
  );

  task automatic put(input int lane, input logic [1:0] op, input logic [7:0] a,
                     input logic [31:0] d, input logic [31:0] e, input string tag);
    exp_t it;
    req_valid[lane]          = 1'b1;
    req_op[2*lane +: 2]      = op;
    req_addr[AW*lane +: AW]  = a;
    req_wdata[DW*lane +: DW] = d;
    it.lane = lane; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic one(input int lane, input logic [1:0] op, input logic [7:0] a,
                     input logic [31:0] d, input logic [31:0] e, input string tag);
    @(negedge clk);
    req_valid = '0;
    put(lane, op, a, d, e, tag);
  endtask

  task automatic two(input logic [1:0] o0, input logic [7:0] a0, input logic [31:0] d0,
                     input logic [31:0] e0, input logic [1:0] o1, input logic [7:0] a1,
                     input logic [31:0] d1, input logic [31:0] e1, input string tag);
    @(negedge clk);
    req_valid = '0;
    put(0, o0, a0, d0, e0, tag);
    put(1, o1, a1, d1, e1, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = '0;
    end
  endtask

  // monitor: compare each response against the queue front
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < N; k++) begin
        if (rsp_valid[k]) begin
          checks++;
          if (q.size() == 0) begin
            errors++;
            $display("FAIL R2 lane %0d: actual unexpected response %h, expected none",
                     k, rsp_data[DW*k +: DW]);
          end else begin
            exp_t it;
            it = q.pop_front();
            if (it.lane != k || rsp_data[DW*k +: DW] !== it.exp) begin
              errors++;
              $display("FAIL %s lane %0d: actual %h, expected %h on lane %0d",
                       it.tag, k, rsp_data[DW*k +: DW], it.exp, it.lane);
            end
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== '0) begin
      errors++;
      $display("FAIL R1: actual rsp_valid %b, expected 00", rsp_valid);
    end
    rst_n = 1'b1;

    // R1 zero memory, no reservation; R6 sc without reservation
    two(LD, 8'h10, 0, 0,   SC, 8'h10, 32'h5, 0, "R1");
    one(0, LD, 8'h10, 0, 0, "R6");
    // R3 store and byte offset ignored
    one(0, ST, 8'h10, 32'h11, 0, "R3");
    one(0, LD, 8'h13, 0, 32'h11, "R3");
    // R2 / R4 ll then sc
    one(0, LL, 8'h10, 0, 32'h11, "R2");
    one(0, SC, 8'h12, 32'h22, 1, "R4");
    one(1, LD, 8'h10, 0, 32'h22, "R4");
    // R7 reservation consumed
    one(0, SC, 8'h10, 32'h33, 0, "R7");
    one(1, LD, 8'h10, 0, 32'h22, "R7");
    // R5 other lane store to reserved word
    one(0, LL, 8'h20, 0, 0, "R5");
    one(1, ST, 8'h21, 32'h7, 0, "R5");
    one(0, SC, 8'h20, 32'h9, 0, "R5");
    one(0, LD, 8'h20, 0, 32'h7, "R5");
    // R9 unrelated store and foreign ll leave reservation
    one(0, LL, 8'h20, 0, 32'h7, "R9");
    one(1, ST, 8'h24, 32'h3, 0, "R9");
    one(1, LL, 8'h20, 0, 32'h7, "R9");
    one(0, SC, 8'h20, 32'h8, 1, "R9");
    one(1, SC, 8'h20, 32'h6, 0, "R5");
    one(0, LD, 8'h20, 0, 32'h8, "R5");
    // R6 wrong word; R7 failed sc also clears
    one(0, LL, 8'h30, 0, 0, "R6");
    one(0, SC, 8'h34, 32'h1, 0, "R6");
    one(0, LD, 8'h34, 0, 0, "R6");
    one(0, SC, 8'h30, 32'h1, 0, "R7");
    // R8 same-cycle ordering
    two(ST, 8'h40, 32'hAA, 0,  LD, 8'h40, 0, 32'hAA, "R8");
    two(LL, 8'h44, 0, 0,       LL, 8'h44, 0, 0, "R8");
    two(SC, 8'h44, 32'h1, 1,   SC, 8'h44, 32'h2, 0, "R8");
    one(0, LD, 8'h44, 0, 32'h1, "R8");
    two(ST, 8'h48, 32'h5, 0,   ST, 8'h48, 32'h6, 0, "R8");
    one(0, LD, 8'h48, 0, 32'h6, "R8");
    two(ST, 8'h4C, 32'h77, 0,  LL, 8'h4C, 0, 32'h77, "R8");
    one(1, SC, 8'h4C, 32'h78, 1, "R8");
    two(LL, 8'h50, 0, 0,       ST, 8'h50, 32'h99, 0, "R8");
    one(0, SC, 8'h50, 32'h1, 0, "R8");
    one(0, LD, 8'h50, 0, 32'h99, "R8");
    // R5 lock acquire, contention, release by storing zero
    one(0, LL, 8'h60, 0, 0, "R5");
    one(0, SC, 8'h60, 32'h1, 1, "R5");
    one(1, LL, 8'h60, 0, 32'h1, "R5");
    one(0, ST, 8'h60, 32'h0, 0, "R5");
    one(1, SC, 8'h60, 32'h1, 0, "R5");
    one(1, LL, 8'h60, 0, 0, "R5");
    one(1, SC, 8'h60, 32'h1, 1, "R5");
    one(0, LD, 8'h60, 0, 32'h1, "R5");
    idle(4);

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R2: actual %0d responses missing, expected 0", q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule